// File: doc/BRIEF.md
# Indexed Integer Load Unit

This block executes one register-indexed integer load at a time on a 64-bit datapath. A caller presents an operation code, an update flag, the two register numbers involved (base RA and target RT) and the operand values of RA and RB. The block forms the effective address and issues a single memory read of 1, 2, 4 or 8 bytes. When the response arrives it reshapes the returned bytes by zero fill, sign extension or byte reversal. It then presents a write-back to RT and, for update forms, a write-back of the effective address to RA in the same cycle.

A small control state machine sequences each operation through five states. IDLE waits for work. ISSUE drives the memory request for one cycle. WAIT holds until the memory returns data. WRITE presents the write-back ports for one cycle. FAULT flags a rejected request for one cycle. The transitions are IDLE->ISSUE on a legal issue, IDLE->FAULT on an illegal issue, ISSUE->WAIT always, WAIT->WRITE on response valid, and WRITE->IDLE and FAULT->IDLE always. Memory returns data right-aligned in `mem_rdata`, big-endian within the requested size: the lowest-addressed byte sits in the most significant byte of the returned size.

Top module: `ldx_unit`

## Requirements
- R1: After reset, and while rst_n is low, busy, mem_req, rt_we, ra_we and illegal are all 0.
- R2: For a non-update load, mem_addr is rb_val when ra_num is 0 and ra_val + rb_val (modulo 2^64) otherwise. mem_size encodes the access size as 0=1 byte, 1=2 bytes, 2=4 bytes, 3=8 bytes.
- R3: For an update load, mem_addr is ra_val + rb_val. In the write-back cycle ra_we is 1 together with rt_we, ra_idx equals ra_num and ra_data equals that address. For a non-update load ra_we stays 0.
- R4: Op codes 0 (byte), 1 (halfword) and 3 (word) return the low 1, 2 or 4 bytes of mem_rdata in rt_data with all higher bits zero. Bytes of mem_rdata above the access size never affect rt_data.
- R5: Op codes 2 (halfword) and 4 (word) sign-extend the low 16 or 32 bits of mem_rdata to 64 bits.
- R6: Op code 5 loads all 64 bits of mem_rdata into rt_data unchanged, with mem_size 3.
- R7: Op codes 6, 7 and 8 reverse the byte order of the low 2, 4 or 8 bytes of mem_rdata. The result is zero-filled above 16 or 32 bits for codes 6 and 7.
- R8: An issue is illegal when the op code is 9 to 15, or when the update flag is set together with ra_num of 0, ra_num equal to rt_num, or op code 6 to 8. An illegal issue raises illegal for exactly one cycle, the cycle after issue. It produces no mem_req, no rt_we and no ra_we.
- R9: A legal issue accepted in idle gives a one-cycle mem_req in the next cycle. rt_we is pulsed for one cycle, the cycle after the accepted mem_rvalid. busy is 1 from the mem_req cycle through the write-back cycle and 0 the cycle after. issue_valid has no effect while busy.
- R10: mem_rvalid is ignored unless a request is outstanding. A response outside that window produces no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Operation presented this cycle |
| issue_op | input | 4 | Load operation code (see R4-R8) |
| issue_upd | input | 1 | Update form: write address back to RA |
| ra_num | input | 5 | Base register number |
| rt_num | input | 5 | Target register number |
| ra_val | input | 64 | Contents of the base register |
| rb_val | input | 64 | Contents of the index register |
| busy | output | 1 | Operation in flight; new issues ignored |
| illegal | output | 1 | One-cycle flag for a rejected issue |
| mem_req | output | 1 | One-cycle memory read request |
| mem_addr | output | 64 | Effective address of the read |
| mem_size | output | 2 | Log2 of the access size in bytes |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data, right-aligned, big-endian within size |
| rt_we | output | 1 | Target write-back valid |
| rt_idx | output | 5 | Target register number |
| rt_data | output | 64 | Formatted load result |
| ra_we | output | 1 | Base write-back valid (update forms) |
| ra_idx | output | 5 | Base register number |
| ra_data | output | 64 | Effective address for the base write-back |

## Verification
Most faults in the control state machine show at the ports within one or two cycles. A state that skips WAIT or lingers in ISSUE shows as a missing or doubled mem_req in the cycle after issue. A lost WRITE shows as no rt_we in the cycle after the response, and a stuck state shows as busy still high in the cycle after write-back. Faults in the captured operation appear only at write-back, so every op code is driven with data whose unused upper bytes are nonzero and whose sign bits vary. A stray response in idle and a second issue during WAIT are both checked for a silent result.

// File: rtl/ldx_pkg.sv
package ldx_pkg;

    typedef enum logic [3:0] {
        OP_BYTE_Z  = 4'd0,
        OP_HALF_Z  = 4'd1,
        OP_HALF_S  = 4'd2,
        OP_WORD_Z  = 4'd3,
        OP_WORD_S  = 4'd4,
        OP_DWORD   = 4'd5,
        OP_HALF_RV = 4'd6,
        OP_WORD_RV = 4'd7,
        OP_DWORD_RV = 4'd8
    } ld_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_WRITE,
        ST_FAULT
    } ld_state_e;

    typedef struct packed {
        logic [1:0] size;
        logic       sext;
        logic       brev;
        logic       legal;
    } ld_dec_t;

    function automatic ld_dec_t ld_decode(
        input logic [3:0] op,
        input logic       upd,
        input logic       ra_zero,
        input logic       ra_is_rt
    );
        ld_dec_t d;
        logic    known;
        d     = '0;
        known = 1'b1;
        case (op)
            OP_BYTE_Z:   d.size = 2'd0;
            OP_HALF_Z:   d.size = 2'd1;
            OP_HALF_S:   begin d.size = 2'd1; d.sext = 1'b1; end
            OP_WORD_Z:   d.size = 2'd2;
            OP_WORD_S:   begin d.size = 2'd2; d.sext = 1'b1; end
            OP_DWORD:    d.size = 2'd3;
            OP_HALF_RV:  begin d.size = 2'd1; d.brev = 1'b1; end
            OP_WORD_RV:  begin d.size = 2'd2; d.brev = 1'b1; end
            OP_DWORD_RV: begin d.size = 2'd3; d.brev = 1'b1; end
            default:     known = 1'b0;
        endcase
        d.legal = known && (!upd || (!d.brev && !ra_zero && !ra_is_rt));
        return d;
    endfunction

endpackage

// File: rtl/ldx_agen.sv
module ldx_agen #(
    parameter int XLEN   = 64,
    parameter int REG_AW = 5
) (
    input  logic              upd,
    input  logic [REG_AW-1:0] ra_num,
    input  logic [XLEN-1:0]   ra_val,
    input  logic [XLEN-1:0]   rb_val,
    output logic [XLEN-1:0]   ea
);
    logic [XLEN-1:0] base;

    always_comb begin
        if (upd || (ra_num != '0)) begin
            base = ra_val;
        end else begin
            base = '0;
        end
        ea = base + rb_val;
    end
endmodule

// File: rtl/ldx_fmt.sv
module ldx_fmt #(
    parameter int XLEN = 64
) (
    input  logic [1:0]      size,
    input  logic            sext,
    input  logic            brev,
    input  logic [XLEN-1:0] raw,
    output logic [XLEN-1:0] res
);
    localparam int NB = XLEN / 8;

    always_comb begin
        int   nb;
        logic sbit;
        nb   = 32'd1 << size;
        sbit = sext & !brev & raw[8*nb-1];
        res  = '0;
        for (int k = 0; k < NB; k++) begin
            if (k < nb) begin
                if (brev) begin
                    res[8*k +: 8] = raw[8*(nb-1-k) +: 8];
                end else begin
                    res[8*k +: 8] = raw[8*k +: 8];
                end
            end else begin
                res[8*k +: 8] = {8{sbit}};
            end
        end
    end
endmodule

// File: rtl/ldx_ctrl.sv
module ldx_ctrl
    import ldx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic issue_valid,
    input  logic req_legal,
    input  logic mem_rvalid,
    input  logic upd_q,
    output logic busy,
    output logic mem_req,
    output logic take_ok,
    output logic cap,
    output logic rt_wb,
    output logic ra_wb,
    output logic illegal
);
    ld_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (issue_valid) begin
                    state_d = req_legal ? ST_ISSUE : ST_FAULT;
                end
            end
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT:  if (mem_rvalid) state_d = ST_WRITE;
            ST_WRITE: state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy    = 1'b0;
        mem_req = 1'b0;
        take_ok = 1'b0;
        cap     = 1'b0;
        rt_wb   = 1'b0;
        ra_wb   = 1'b0;
        illegal = 1'b0;
        unique case (state_q)
            ST_IDLE:  take_ok = issue_valid & req_legal;
            ST_ISSUE: begin busy = 1'b1; mem_req = 1'b1; end
            ST_WAIT:  begin busy = 1'b1; cap = mem_rvalid; end
            ST_WRITE: begin busy = 1'b1; rt_wb = 1'b1; ra_wb = upd_q; end
            ST_FAULT: begin busy = 1'b1; illegal = 1'b1; end
            default:  busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/ldx_unit.sv
module ldx_unit
    import ldx_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic [3:0]        issue_op,
    input  logic              issue_upd,
    input  logic [REG_AW-1:0] ra_num,
    input  logic [REG_AW-1:0] rt_num,
    input  logic [XLEN-1:0]   ra_val,
    input  logic [XLEN-1:0]   rb_val,
    output logic              busy,
    output logic              illegal,
    output logic              mem_req,
    output logic [XLEN-1:0]   mem_addr,
    output logic [1:0]        mem_size,
    input  logic              mem_rvalid,
    input  logic [XLEN-1:0]   mem_rdata,
    output logic              rt_we,
    output logic [REG_AW-1:0] rt_idx,
    output logic [XLEN-1:0]   rt_data,
    output logic              ra_we,
    output logic [REG_AW-1:0] ra_idx,
    output logic [XLEN-1:0]   ra_data
);
    ld_dec_t           dec;
    logic [XLEN-1:0]   ea;
    logic [XLEN-1:0]   fmt_res;
    logic              take_ok;
    logic              cap;

    logic [XLEN-1:0]   ea_q;
    logic [XLEN-1:0]   res_q;
    logic [1:0]        size_q;
    logic              sext_q;
    logic              brev_q;
    logic              upd_q;
    logic [REG_AW-1:0] ra_q;
    logic [REG_AW-1:0] rt_q;

    assign dec = ld_decode(issue_op, issue_upd, (ra_num == '0), (ra_num == rt_num));

    ldx_agen #(.XLEN(XLEN), .REG_AW(REG_AW)) u_agen (
        .upd    (issue_upd),
        .ra_num (ra_num),
        .ra_val (ra_val),
        .rb_val (rb_val),
        .ea     (ea)
    );

    ldx_fmt #(.XLEN(XLEN)) u_fmt (
        .size (size_q),
        .sext (sext_q),
        .brev (brev_q),
        .raw  (mem_rdata),
        .res  (fmt_res)
    );

    ldx_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_valid (issue_valid),
        .req_legal   (dec.legal),
        .mem_rvalid  (mem_rvalid),
        .upd_q       (upd_q),
        .busy        (busy),
        .mem_req     (mem_req),
        .take_ok     (take_ok),
        .cap         (cap),
        .rt_wb       (rt_we),
        .ra_wb       (ra_we),
        .illegal     (illegal)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_q   <= '0;
            res_q  <= '0;
            size_q <= '0;
            sext_q <= 1'b0;
            brev_q <= 1'b0;
            upd_q  <= 1'b0;
            ra_q   <= '0;
            rt_q   <= '0;
        end else begin
            if (take_ok) begin
                ea_q   <= ea;
                size_q <= dec.size;
                sext_q <= dec.sext;
                brev_q <= dec.brev;
                upd_q  <= issue_upd;
                ra_q   <= ra_num;
                rt_q   <= rt_num;
            end
            if (cap) begin
                res_q <= fmt_res;
            end
        end
    end

    assign mem_addr = ea_q;
    assign mem_size = size_q;
    assign rt_idx   = rt_q;
    assign rt_data  = res_q;
    assign ra_idx   = ra_q;
    assign ra_data  = ea_q;
endmodule

// File: rtl/ldx_unit_chk.sv
module ldx_unit_chk #(
    parameter int XLEN   = 64,
    parameter int REG_AW = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              illegal,
    input logic              mem_req,
    input logic [1:0]        mem_size,
    input logic              rt_we,
    input logic [REG_AW-1:0] rt_idx,
    input logic [XLEN-1:0]   rt_data,
    input logic              ra_we,
    input logic [REG_AW-1:0] ra_idx
);
    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req); // R9
    AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy); // R9
    AST_WB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rt_we |=> (!rt_we && !busy)); // R9
    AST_RA_WITH_RT: assert property (@(posedge clk) disable iff (!rst_n)
        ra_we |-> rt_we); // R3
    AST_RA_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        ra_we |-> ((ra_idx != '0) && (ra_idx != rt_idx))); // R8
    AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!mem_req && !rt_we && !ra_we)); // R8
    AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> !illegal); // R8
    AST_BYTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_we && mem_size == 2'd0) |-> (rt_data[XLEN-1:8] == '0)); // R4
endmodule

bind ldx_unit ldx_unit_chk #(.XLEN(XLEN), .REG_AW(REG_AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .illegal  (illegal),
    .mem_req  (mem_req),
    .mem_size (mem_size),
    .rt_we    (rt_we),
    .rt_idx   (rt_idx),
    .rt_data  (rt_data),
    .ra_we    (ra_we),
    .ra_idx   (ra_idx)
);

// File: tb/ldx_unit_tb.sv
module ldx_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [3:0]  issue_op = '0;
    logic        issue_upd = 1'b0;
    logic [4:0]  ra_num = '0;
    logic [4:0]  rt_num = '0;
    logic [63:0] ra_val = '0;
    logic [63:0] rb_val = '0;
    logic        mem_rvalid = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        busy, illegal, mem_req, rt_we, ra_we;
    logic [63:0] mem_addr, rt_data, ra_data;
    logic [1:0]  mem_size;
    logic [4:0]  rt_idx, ra_idx;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ldx_unit u_dut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_op(issue_op),
        .issue_upd(issue_upd), .ra_num(ra_num), .rt_num(rt_num), .ra_val(ra_val),
        .rb_val(rb_val), .busy(busy), .illegal(illegal), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_size(mem_size), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .rt_we(rt_we), .rt_idx(rt_idx), .rt_data(rt_data),
        .ra_we(ra_we), .ra_idx(ra_idx), .ra_data(ra_data)
    );

    typedef struct packed {
        logic [3:0]  op;
        logic        upd;
        logic [4:0]  ra;
        logic [4:0]  rt;
        logic [63:0] rav;
        logic [63:0] rbv;
        logic [63:0] dat;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{4'd0, 1'b0, 5'd0,  5'd4,  64'h1000, 64'h20, 64'hDEADBEEF_CAFEF0A5},
        '{4'd1, 1'b0, 5'd3,  5'd4,  64'h1000, 64'h22, 64'h77777777_77778001},
        '{4'd2, 1'b0, 5'd3,  5'd5,  64'h1000, 64'hFFFFFFFF_FFFFFFF0, 64'h12345678_9ABC8001},
        '{4'd2, 1'b1, 5'd7,  5'd8,  64'h2000, 64'h6, 64'hFFFFFFFF_FFFF7FFE},
        '{4'd3, 1'b1, 5'd2,  5'd9,  64'h3000, 64'h40, 64'hAAAAAAAA_F2345678},
        '{4'd4, 1'b0, 5'd1,  5'd1,  64'h4000, 64'h4, 64'h01010101_89ABCDEF},
        '{4'd5, 1'b1, 5'd31, 5'd30, 64'hFFFFFFFF_FFFFFFF8, 64'h10, 64'h80112233_44556677},
        '{4'd6, 1'b0, 5'd0,  5'd2,  64'h5555, 64'h100, 64'hFFFFFFFF_FFFF1234},
        '{4'd7, 1'b0, 5'd6,  5'd3,  64'h8000, 64'h8, 64'hCCCCCCCC_12345678},
        '{4'd8, 1'b0, 5'd6,  5'd3,  64'h8000, 64'h18, 64'h01020304_05060708},
        '{4'd0, 1'b1, 5'd5,  5'd6,  64'h9000, 64'h1, 64'hFFFFFFFF_FFFFFF80},
        '{4'd4, 1'b1, 5'd9,  5'd10, 64'hA000, 64'hC, 64'hFFFFFFFF_7FFFFFFF}
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_size(input logic [3:0] op);
        case (op)
            4'd0: return 2'd0;
            4'd1, 4'd2, 4'd6: return 2'd1;
            4'd3, 4'd4, 4'd7: return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

    function automatic logic [63:0] exp_data(input logic [3:0] op, input logic [63:0] d);
        logic [63:0] r;
        case (op)
            4'd0: r = {56'b0, d[7:0]};
            4'd1: r = {48'b0, d[15:0]};
            4'd2: r = {{48{d[15]}}, d[15:0]};
            4'd3: r = {32'b0, d[31:0]};
            4'd4: r = {{32{d[31]}}, d[31:0]};
            4'd5: r = d;
            4'd6: r = {48'b0, d[7:0], d[15:8]};
            4'd7: r = {32'b0, d[7:0], d[15:8], d[23:16], d[31:24]};
            default: begin
                for (int i = 0; i < 8; i++) r[8*i +: 8] = d[8*(7-i) +: 8];
            end
        endcase
        return r;
    endfunction

    task automatic drive_issue(input logic [3:0] op, input logic upd, input logic [4:0] ra,
                               input logic [4:0] rt, input logic [63:0] rav, input logic [63:0] rbv);
        @(negedge clk);
        issue_valid = 1'b1; issue_op = op; issue_upd = upd;
        ra_num = ra; rt_num = rt; ra_val = rav; rb_val = rbv;
        @(negedge clk);
        issue_valid = 1'b0;
    endtask

    task automatic run_load(input vec_t v, input int lat);
        logic [63:0] ea;
        ea = (v.upd || v.ra != 0) ? v.rav + v.rbv : v.rbv;
        drive_issue(v.op, v.upd, v.ra, v.rt, v.rav, v.rbv);
        chk(mem_req == 1'b1, "R9 mem_req after issue", 64'(mem_req), 64'd1);
        chk(busy == 1'b1, "R9 busy in request", 64'(busy), 64'd1);
        chk(mem_addr == ea, v.upd ? "R3 update address" : "R2 address", mem_addr, ea);
        chk(mem_size == exp_size(v.op), "R2 size", 64'(mem_size), 64'(exp_size(v.op)));
        repeat (lat + 1) begin
            @(negedge clk);
            chk(mem_req == 1'b0 && rt_we == 1'b0, "R9 single request", 64'(mem_req), 64'd0);
        end
        mem_rvalid = 1'b1; mem_rdata = v.dat;
        @(negedge clk);
        mem_rvalid = 1'b0; mem_rdata = 64'h5A5A_A5A5_0F0F_F0F0;
        chk(rt_we == 1'b1, "R9 write-back after response", 64'(rt_we), 64'd1);
        chk(rt_idx == v.rt, "R9 target index", 64'(rt_idx), 64'(v.rt));
        chk(rt_data == exp_data(v.op, v.dat), "R4 R5 R6 R7 formatted data", rt_data, exp_data(v.op, v.dat));
        chk(ra_we == v.upd, "R3 base write enable", 64'(ra_we), 64'(v.upd));
        if (v.upd) begin
            chk(ra_idx == v.ra && ra_data == ea, "R3 base write-back", ra_data, ea);
        end
        @(negedge clk);
        chk(rt_we == 1'b0 && busy == 1'b0, "R9 return to idle", {62'b0, rt_we, busy}, 64'd0);
    endtask

    task automatic run_bad(input logic [3:0] op, input logic upd, input logic [4:0] ra, input logic [4:0] rt);
        drive_issue(op, upd, ra, rt, 64'h100, 64'h200);
        chk(illegal == 1'b1, "R8 illegal flag", 64'(illegal), 64'd1);
        chk(mem_req == 1'b0 && rt_we == 1'b0 && ra_we == 1'b0, "R8 no side effects",
            {61'b0, mem_req, rt_we, ra_we}, 64'd0);
        @(negedge clk);
        chk(illegal == 1'b0 && busy == 1'b0 && mem_req == 1'b0, "R8 single-cycle flag",
            {61'b0, illegal, busy, mem_req}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 0 && mem_req == 0 && rt_we == 0 && ra_we == 0 && illegal == 0,
            "R1 reset quiet", {59'b0, busy, mem_req, rt_we, ra_we, illegal}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && mem_req == 0 && rt_we == 0, "R1 idle after reset",
            {61'b0, busy, mem_req, rt_we}, 64'd0);

        for (int i = 0; i < NV; i++) begin
            run_load(VEC[i], i % 3);
        end

        // R10: stray response while idle
        @(negedge clk);
        mem_rvalid = 1'b1; mem_rdata = 64'hFF;
        @(negedge clk);
        @(negedge clk);
        mem_rvalid = 1'b0;
        chk(rt_we == 1'b0 && mem_req == 0 && busy == 0, "R10 stray response ignored",
            {61'b0, rt_we, mem_req, busy}, 64'd0);

        // R8 illegal forms
        run_bad(4'd1, 1'b1, 5'd0, 5'd4);
        run_bad(4'd3, 1'b1, 5'd7, 5'd7);
        run_bad(4'd7, 1'b1, 5'd2, 5'd3);
        run_bad(4'd9, 1'b0, 5'd2, 5'd3);
        run_bad(4'd15, 1'b0, 5'd0, 5'd3);

        // R9: issue held high while busy is ignored
        @(negedge clk);
        issue_valid = 1'b1; issue_op = 4'd3; issue_upd = 1'b0;
        ra_num = 5'd4; rt_num = 5'd11; ra_val = 64'h40; rb_val = 64'h4;
        @(negedge clk);
        issue_op = 4'd5; rt_num = 5'd12; ra_val = 64'h9999;
        chk(mem_addr == 64'h44, "R9 first issue address", mem_addr, 64'h44);
        repeat (2) begin
            @(negedge clk);
            chk(mem_req == 1'b0, "R9 issue ignored while busy", 64'(mem_req), 64'd0);
        end
        mem_rvalid = 1'b1; mem_rdata = 64'h11111111_CAFEBABE;
        @(negedge clk);
        mem_rvalid = 1'b0;
        issue_valid = 1'b0;
        chk(rt_idx == 5'd11 && rt_data == 64'hCAFEBABE, "R9 first operation kept", rt_data, 64'hCAFEBABE);
        @(negedge clk);
        chk(mem_req == 1'b0 && busy == 1'b0, "R9 no late acceptance", {62'b0, mem_req, busy}, 64'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule